// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two 32-bit floating-point words in the standard single-precision layout: the sign is bit 31, the 8-bit exponent with bias 127 sits in bits 30..23, and the 23-bit fraction sits in bits 22..0. A normal word stands for (-1)^sign x (1 + fraction/2^23) x 2^(exponent-127), and the leading 1 is implied rather than stored. A subtraction is an addition with the sign of the second operand inverted.

The datapath works in a fixed order. It first sorts out special and zero operands. It then shifts the smaller significand right to line up the binary points, adds or subtracts the magnitudes, and normalizes the sum. Last, it rounds to nearest with ties to even, using a guard bit, a round bit and a sticky bit. When the final exponent leaves the normal range, the unit raises an overflow or underflow flag next to a saturated result.

The result appears on a registered output one cycle after the operands are presented with `in_valid`. The output holds its value while `in_valid` is low.

Top module: `fp32_addsub`

## Requirements
- R1: For two normal operands whose sum is in range, `result` equals the exact sum rounded to 24 significant bits, with the sign in bit 31, the biased exponent in bits 30..23 and the fraction in bits 22..0; both flags are 0.
- R2: With `sub_sel`=1 the unit returns `op_a` + (`op_b` with bit 31 inverted); with `sub_sel`=0 it returns `op_a` + `op_b`.
- R3: If `op_a` is zero (exponent field 0), the result is the effective second operand (sign inverted when subtracting). Otherwise, if `op_b` is zero, the result is `op_a`. An effective operand with exponent field 0 is returned as a signed zero. The flags stay 0.
- R4: The smaller-exponent significand is shifted right by the exponent difference. Bits shifted out feed a sticky bit, and rounding is to nearest with ties to even.
- R5: After a cancelling subtraction, the sum is shifted left until its leading 1 is in the hidden position, and the exponent drops by the shift amount.
- R6: When rounding carries out of the 24-bit significand, the significand becomes 1.0 and the exponent increases by one.
- R7: If the final biased exponent is 255 or more, the result is infinity with the sum's sign (exponent field 255, fraction 0) and `ovf_flag`=1.
- R8: If the final biased exponent is 0 or less for a nonzero sum, the result is a zero with the sum's sign and `unf_flag`=1.
- R9: A sum that cancels exactly to zero gives +0 (32'h00000000) with both flags 0.
- R10: A NaN operand (exponent 255, fraction nonzero), or infinities of opposite effective sign, give the quiet NaN 32'h7FC00000. Otherwise an infinite operand gives infinity with that operand's effective sign. The flags stay 0.
- R11: An operand with exponent field 0 and a nonzero fraction is treated as zero.
- R12: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. `result` and the flags change only after a cycle with `in_valid`=1 and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| out_valid | output | 1 | result and flags hold a new value |
| result | output | 32 | Rounded sum or difference |
| ovf_flag | output | 1 | Exponent overflow; result is signed infinity |
| unf_flag | output | 1 | Exponent underflow; result is signed zero |

## Verification
The main arithmetic is tried with three input patterns, and each separates a different class of fault.
- A full sweep crosses exponents at the range edges with fractions of 0, 1 LSB, half, all-ones and alternating bits, for both signs and both operations. It separates the special, zero, overflow and underflow paths from the plain arithmetic path.
- Random operand pairs with unrelated exponents stress the alignment shift and the sticky bit.
- Pairs with nearly equal magnitudes and opposite effective signs force deep cancellation, which tells apart a correct leading-zero normalizer from one that is off by a position.

Directed vectors cover the exact halfway ties, the rounding carry into a new binade, the 2^-149 difference at the bottom of the normal range, and the holding of the output while idle.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  // operand class after decoding the exponent and fraction fields
  typedef enum logic [1:0] {
    K_ZERO = 2'd0,
    K_NORM = 2'd1,
    K_INF  = 2'd2,
    K_NAN  = 2'd3
  } fp_kind_e;

  // number of extra low bits kept below the significand: guard, round, sticky
  localparam int unsigned XTRA = 3;

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  input  logic                  flip,
  output logic                  sgn,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W:0]       sig,
  output fp_kind_e              kind
);
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};

  logic [FRAC_W-1:0] frac;

  always_comb begin
    sgn  = word[EXP_W+FRAC_W] ^ flip;
    expo = word[EXP_W+FRAC_W-1:FRAC_W];
    frac = word[FRAC_W-1:0];
    sig  = {1'b1, frac};
    if (expo == '0)        kind = K_ZERO;  // subnormals fold into zero
    else if (expo != EMAX) kind = K_NORM;
    else if (frac == '0)   kind = K_INF;
    else                   kind = K_NAN;
  end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned WX    = SIG_W + XTRA
) (
  input  logic             sa,
  input  logic [EXP_W-1:0] ea,
  input  logic [SIG_W-1:0] ma,
  input  logic             sb,
  input  logic [EXP_W-1:0] eb,
  input  logic [SIG_W-1:0] mb,
  output logic             s_big,
  output logic [EXP_W-1:0] e_big,
  output logic [WX-1:0]    big_x,
  output logic [WX-1:0]    small_x,
  output logic             eff_sub
);
  logic             swap;
  logic [EXP_W-1:0] e_small, diff;
  logic [SIG_W-1:0] m_big, m_small;
  logic [WX-1:0]    ext, shifted, lost;
  logic             sticky;

  always_comb begin
    swap    = {eb, mb} > {ea, ma};
    s_big   = swap ? sb : sa;
    e_big   = swap ? eb : ea;
    m_big   = swap ? mb : ma;
    e_small = swap ? ea : eb;
    m_small = swap ? ma : mb;
    eff_sub = sa ^ sb;
    diff    = e_big - e_small;
    big_x   = {m_big, {XTRA{1'b0}}};
    ext     = {m_small, {XTRA{1'b0}}};
    if (int'(diff) >= int'(WX)) begin
      shifted = '0;
      lost    = ext;
    end else begin
      shifted = ext >> diff;
      lost    = ext & ~({WX{1'b1}} << diff);
    end
    sticky  = |lost;
    small_x = shifted | {{(WX-1){1'b0}}, sticky};
  end

endmodule

// File: rtl/fpadd_sumnorm.sv
module fpadd_sumnorm
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned WX    = SIG_W + XTRA,
  localparam int unsigned LZW   = $clog2(WX + 1),
  localparam int unsigned EW2   = EXP_W + 2
) (
  input  logic                  s_big,
  input  logic [EXP_W-1:0]      e_big,
  input  logic [WX-1:0]         big_x,
  input  logic [WX-1:0]         small_x,
  input  logic                  eff_sub,
  output logic [EXP_W+FRAC_W:0] res_word,
  output logic                  ovf,
  output logic                  unf
);
  localparam logic [EXP_W-1:0]     EMAX   = {EXP_W{1'b1}};
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
  localparam logic signed [EW2-1:0] ZERO_S = '0;

  logic [WX:0]             sum;
  logic [LZW-1:0]          lz;
  logic [WX-1:0]           norm;
  logic signed [EW2-1:0]   e_n, e_f;
  logic [SIG_W-1:0]        keep, sig_f;
  logic [SIG_W:0]          rnd;
  logic                    up, is_zero;

  always_comb begin
    sum = eff_sub ? ({1'b0, big_x} - {1'b0, small_x})
                  : ({1'b0, big_x} + {1'b0, small_x});
    is_zero = (sum == '0);
    lz = '0;
    for (int i = 0; i < int'(WX); i++) begin
      if (sum[i]) lz = LZW'(int'(WX) - 1 - i);
    end
    if (sum[WX]) begin
      norm = {sum[WX:2], |sum[1:0]};
      e_n  = EW2'(e_big) + EW2'(1);
    end else begin
      norm = sum[WX-1:0] << lz;
      e_n  = EW2'(e_big) - EW2'(lz);
    end
    // round to nearest, ties to even
    keep = norm[WX-1:XTRA];
    up   = norm[XTRA-1] & ((|norm[XTRA-2:0]) | keep[0]);
    rnd  = {1'b0, keep} + {{SIG_W{1'b0}}, up};
    if (rnd[SIG_W]) begin
      sig_f = rnd[SIG_W:1];
      e_f   = e_n + EW2'(1);
    end else begin
      sig_f = rnd[SIG_W-1:0];
      e_f   = e_n;
    end
    ovf = !is_zero && (e_f >= EMAX_S);
    unf = !is_zero && (e_f <= ZERO_S);
    if (is_zero)  res_word = '0;
    else if (ovf) res_word = {s_big, EMAX, {FRAC_W{1'b0}}};
    else if (unf) res_word = {s_big, {(EXP_W+FRAC_W){1'b0}}};
    else          res_word = {s_big, e_f[EXP_W-1:0], sig_f[FRAC_W-1:0]};
  end

  // R5: a nonzero sum always leaves normalization with its leading 1 on top
  always_comb begin
    if (!is_zero) begin
      assert_norm_msb_R5: assert (norm[WX-1]) else $error("normalizer left MSB clear");
      assert_round_msb_R6: assert (sig_f[SIG_W-1]) else $error("rounded significand lost hidden bit");
    end
  end

endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fpadd_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W = FRAC_W + 1,
  localparam int unsigned WX    = SIG_W + XTRA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_sel,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf_flag,
  output logic         unf_flag
);
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  logic rst_meta, rst_q;

  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb, e_big;
  logic [SIG_W-1:0] ma, mb;
  fp_kind_e         ka, kb;
  logic             s_big, eff_sub;
  logic [WX-1:0]    big_x, small_x;
  logic [W-1:0]     arith_word;
  logic             arith_ovf, arith_unf;

  logic [W-1:0] nxt_result, result_q;
  logic         nxt_ovf, nxt_unf, ovf_q, unf_q, valid_q;

  fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .word(op_a), .flip(1'b0), .sgn(sa), .expo(ea), .sig(ma), .kind(ka));

  fpadd_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .word(op_b), .flip(sub_sel), .sgn(sb), .expo(eb), .sig(mb), .kind(kb));

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sa(sa), .ea(ea), .ma(ma), .sb(sb), .eb(eb), .mb(mb),
    .s_big(s_big), .e_big(e_big), .big_x(big_x), .small_x(small_x),
    .eff_sub(eff_sub));

  fpadd_sumnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sum (
    .s_big(s_big), .e_big(e_big), .big_x(big_x), .small_x(small_x),
    .eff_sub(eff_sub), .res_word(arith_word), .ovf(arith_ovf), .unf(arith_unf));

  // next-state selection: specials, then zero check, then arithmetic
  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    if (ka == K_NAN || kb == K_NAN || (ka == K_INF && kb == K_INF && sa != sb))
      nxt_result = QNAN;
    else if (ka == K_INF)
      nxt_result = {sa, EMAX, {FRAC_W{1'b0}}};
    else if (kb == K_INF)
      nxt_result = {sb, EMAX, {FRAC_W{1'b0}}};
    else if (ka == K_ZERO)
      nxt_result = (kb == K_ZERO) ? {sb, {(W-1){1'b0}}} : {sb, op_b[W-2:0]};
    else if (kb == K_ZERO)
      nxt_result = {sa, op_a[W-2:0]};
    else begin
      nxt_result = arith_word;
      nxt_ovf    = arith_ovf;
      nxt_unf    = arith_unf;
    end
  end

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= nxt_result;
        ovf_q    <= nxt_ovf;
        unf_q    <= nxt_unf;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;

  assert_valid_R12: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(result)));
  assert_ovf_inf_R7: assert property (@(posedge clk) disable iff (!rst_q)
    ovf_q |-> (result_q[W-2:0] == {EMAX, {FRAC_W{1'b0}}}));
  assert_unf_zero_R8: assert property (@(posedge clk) disable iff (!rst_q)
    unf_q |-> (result_q[W-2:0] == '0));
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !(ovf_q && unf_q));
  assert_qnan_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (result_q[W-2:FRAC_W] == EMAX && result_q[FRAC_W-1:0] != '0) |-> (result_q == QNAN));

endmodule

// File: tb/sim_fp32_addsub.sv
`timescale 1ns/1ps
module sim_fp32_addsub;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        sub_sel;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_flag, unf_flag;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  fp32_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  // expected value from the requirements: {ovf, unf, result}
  function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic sub, output string tag);
    logic sa, sb, s;
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    logic an, bn, ai, bi, az, bz;
    logic [63:0] d;
    logic [52:0] m53;
    logic [23:0] keep;
    logic [24:0] k25;
    logic g, rest, up;
    real ra, rb;
    int e, be;
    sa = a[31]; ea = a[30:23]; fa = a[22:0];
    sb = b[31] ^ sub; eb = b[30:23]; fb = b[22:0];
    an = (ea == 8'hFF) && (fa != 0); ai = (ea == 8'hFF) && (fa == 0); az = (ea == 0);
    bn = (eb == 8'hFF) && (fb != 0); bi = (eb == 8'hFF) && (fb == 0); bz = (eb == 0);
    tag = "R10";
    if (an || bn || (ai && bi && sa != sb)) return {2'b00, 32'h7FC00000};
    if (ai) return {2'b00, sa, 8'hFF, 23'h0};
    if (bi) return {2'b00, sb, 8'hFF, 23'h0};
    tag = (az || bz) && ((ea == 0 && fa != 0) || (eb == 0 && fb != 0)) ? "R11" : "R3";
    if (az) return bz ? {2'b00, sb, 31'h0} : {2'b00, sb, b[30:0]};
    if (bz) return {2'b00, sa, a[30:0]};
    ra = $bitstoreal({sa, 11'(ea) + 11'd896, fa, 29'h0});
    rb = $bitstoreal({sb, 11'(eb) + 11'd896, fb, 29'h0});
    d = $realtobits(ra + rb);
    tag = "R9";
    if (d[62:0] == 0) return 34'h0;
    s    = d[63];
    m53  = {1'b1, d[51:0]};
    keep = m53[52:29];
    g    = m53[28];
    rest = |m53[27:0];
    up   = g & (rest | keep[0]);
    k25  = {1'b0, keep} + 25'(up);
    e    = int'(d[62:52]) - 1023;
    if (k25[24]) begin keep = k25[24:1]; e = e + 1; end
    else keep = k25[23:0];
    be = e + 127;
    tag = "R7";
    if (be > 254) return {2'b10, s, 8'hFF, 23'h0};
    tag = "R8";
    if (be < 1) return {2'b01, s, 31'h0};
    tag = "R1";
    return {2'b00, s, 8'(be), keep[22:0]};
  endfunction

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%09h expected=%09h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       output logic [33:0] got);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = sub; in_valid = 1'b1;
    @(posedge clk);
    #1;
    got = {ovf_flag, unf_flag, result};
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL R12 out_valid actual=%0b expected=1", out_valid);
    end
  endtask

  // run through the model and compare
  task automatic vec(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic [33:0] got, exp;
    string tag;
    exp = model(a, b, sub, tag);
    apply(a, b, sub, got);
    check(tag, got, exp);
  endtask

  // directed vector with a hand-computed expectation
  task automatic dvec(input string tag, input logic [31:0] a, input logic [31:0] b,
                      input logic sub, input logic [33:0] exp);
    logic [33:0] got;
    apply(a, b, sub, got);
    check(tag, got, exp);
  endtask

  task automatic run_all();
    logic [7:0]  exps [11] = '{8'd0, 8'd1, 8'd2, 8'd100, 8'd126, 8'd127, 8'd128,
                               8'd150, 8'd253, 8'd254, 8'd255};
    logic [22:0] fracs [6] = '{23'h0, 23'h1, 23'h400000, 23'h7FFFFF, 23'h2AAAAA, 23'h555555};
    logic [31:0] lfsr = 32'h1234_5678;
    logic [33:0] held;

    // reset state
    checks++;
    if ({out_valid, ovf_flag, unf_flag, result} !== 35'h0) begin
      failures++;
      $display("FAIL R12 reset actual=%09h expected=0", {out_valid, ovf_flag, unf_flag, result});
    end

    dvec("R1", 32'h3F800000, 32'h3F800000, 1'b0, {2'b00, 32'h40000000});
    dvec("R1", 32'h3FC00000, 32'h3E800000, 1'b0, {2'b00, 32'h3FE00000});
    dvec("R2", 32'h3F800000, 32'h3F000000, 1'b1, {2'b00, 32'h3F000000});
    dvec("R2", 32'h3F800000, 32'hBF000000, 1'b1, {2'b00, 32'h3FC00000});
    dvec("R5", 32'h3F000000, 32'h3EE00000, 1'b1, {2'b00, 32'h3D800000});
    dvec("R3", 32'h00000000, 32'h40400000, 1'b0, {2'b00, 32'h40400000});
    dvec("R3", 32'h00000000, 32'h40400000, 1'b1, {2'b00, 32'hC0400000});
    dvec("R3", 32'h40A00000, 32'h80000000, 1'b0, {2'b00, 32'h40A00000});
    dvec("R9", 32'h40400000, 32'h40400000, 1'b1, {2'b00, 32'h00000000});
    dvec("R9", 32'hC0400000, 32'h40400000, 1'b0, {2'b00, 32'h00000000});
    dvec("R4", 32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000});
    dvec("R4", 32'h3F800001, 32'h33800000, 1'b0, {2'b00, 32'h3F800002});
    dvec("R4", 32'h3F800000, 32'h33800001, 1'b0, {2'b00, 32'h3F800001});
    dvec("R6", 32'h3FFFFFFF, 32'h33800000, 1'b0, {2'b00, 32'h40000000});
    dvec("R7", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000});
    dvec("R7", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, {2'b10, 32'hFF800000});
    dvec("R8", 32'h00800001, 32'h00800000, 1'b1, {2'b01, 32'h00000000});
    dvec("R8", 32'h00800000, 32'h00800001, 1'b1, {2'b01, 32'h80000000});
    dvec("R10", 32'h7F800001, 32'h3F800000, 1'b0, {2'b00, 32'h7FC00000});
    dvec("R10", 32'h7F800000, 32'h7F800000, 1'b1, {2'b00, 32'h7FC00000});
    dvec("R10", 32'h7F800000, 32'h3F800000, 1'b0, {2'b00, 32'h7F800000});
    dvec("R10", 32'h3F800000, 32'h7F800000, 1'b1, {2'b00, 32'hFF800000});
    dvec("R11", 32'h00000005, 32'h3F800000, 1'b0, {2'b00, 32'h3F800000});
    dvec("R11", 32'h3F800000, 32'h00400000, 1'b1, {2'b00, 32'h3F800000});
    dvec("R11", 32'h00400000, 32'h40000000, 1'b1, {2'b00, 32'hC0000000});

    // R12: idle cycle with new operands must not move the output
    dvec("R12", 32'h3F800000, 32'h3F800000, 1'b0, {2'b00, 32'h40000000});
    held = {ovf_flag, unf_flag, result};
    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h7F7FFFFF; op_b = 32'h7F7FFFFF;
    @(posedge clk);
    #1;
    check("R12", {ovf_flag, unf_flag, result}, held);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R12 idle out_valid actual=%0b expected=0", out_valid);
    end

    // sweep of edge exponents and fraction patterns (R1 R3 R7 R8 R10 R11)
    for (int op = 0; op < 2; op++)
      for (int ia = 0; ia < 132; ia++)
        for (int ib = 0; ib < 132; ib++)
          vec({ia[0], exps[ia / 12], fracs[(ia / 2) % 6]},
              {ib[0], exps[ib / 12], fracs[(ib / 2) % 6]}, op[0]);

    // random pairs (R4 alignment) and near-cancelling pairs (R5)
    for (int n = 0; n < 8000; n++) begin
      logic [31:0] ra, rb;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      ra = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      rb = lfsr;
      vec(ra, rb, rb[7]);
      vec(ra, {ra[31], ra[30:0] ^ (rb[30:0] & 32'h00FFFFFF)}, 1'b1);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; sub_sel = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    fork
      begin
        run_all();
      end
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule